// File: doc/BRIEF.md
# Programmable Watchdog Timer with Expiry Steering

This block is a watchdog timer controlled through one byte-wide control register. The register holds a steering bit, a 5-bit multiplier and a 2-bit resolution code; the timeout is the multiplier scaled by four raised to the resolution, counted in periods of an external 1/16 s tick. Software keeps the watchdog alive by rewriting the control register or by reading it back. Either access restarts the count.

When the count runs out, a sticky expiry flag is raised. The steering bit then picks what happens next. With the bit clear, the block raises a single-cycle interrupt pulse and stops counting until software restarts it. With the bit set, the block clears its control register and raises a single-cycle system reset request. In that same cycle it raises a pulse that tells the neighbouring calendar logic to clear its mode bit. The expiry flag is an output only, so the host cannot write it directly.

Top module: `wdog_steer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the control register (reads 0x00), clears the expiry flag, drops all pulses and leaves the counter idle, so later ticks cause no expiry until a restart.
- R2: Control register layout: bit 7 is the steering bit, bits [6:2] the multiplier M and bits [1:0] the resolution code R. The timeout is M * 4^R tick periods. Expiry takes place at the clock edge that samples the (M * 4^R)-th tick after the restart, and the outputs show it from that edge on.
- R3: A multiplier of zero, which includes writing 0x00, leaves the timer disabled. No number of ticks then causes an expiry.
- R4: A write stores the written byte, which reads back from the next cycle. It clears the expiry flag and restarts the count with the timeout of the new value.
- R5: A read restarts the count with the timeout of the stored value. It changes neither the stored value nor the expiry flag.
- R6: On expiry the expiry flag goes to 1. It stays at 1 until the next write or reset.
- R7: If bit 7 is 0 at expiry, `irq_pulse_o` is high for exactly one cycle and the register keeps its value. The counter then stays idle, and further ticks cause no expiry until the next write or read.
- R8: If bit 7 is 1 at expiry, the register is cleared to 0x00, and `sys_rst_req_o` and `mode_clr_o` are high for exactly one cycle. No interrupt pulse is raised.
- R9: A write or read in the same cycle as the final tick restarts the count, and no expiry takes place. A write and a read in the same cycle act as a write.
- R10: Only cycles with `tick_i` high advance the count. Cycles without a tick leave the remaining time unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse per 1/16 s period |
| reg_wr_i | input | 1 | Write strobe for the control register |
| reg_rd_i | input | 1 | Read strobe for the control register (restarts the count) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Current control register value |
| wd_flag_o | output | 1 | Sticky expiry flag |
| irq_pulse_o | output | 1 | One-cycle interrupt pulse on expiry in interrupt mode |
| sys_rst_req_o | output | 1 | One-cycle system reset request on expiry in reset mode |
| mode_clr_o | output | 1 | One-cycle request to clear the neighbouring calendar mode bit |

## Verification
A register access takes effect at the edge that samples it, so the stored value and the cleared flag are due one cycle after the write. An expiry is due in the same registered cycle as the edge that samples the final tick. On that edge the flag, the pulse and the cleared register all appear together, and the pulse is gone one cycle later. The bench drives every input on the falling edge, advances exactly one rising edge per step, and compares the outputs on the following falling edge. Each expected value is therefore tied to a known count of edges since the stimulus, including the full 1984-tick timeout, where the cycle one tick early is checked as well.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    // what happens when the count runs out
    typedef enum logic [0:0] {
        ACT_IRQ = 1'b0,
        ACT_RST = 1'b1
    } steer_e;
endpackage

// File: rtl/wdog_tmo_calc.sv
// Converts multiplier and resolution code into a tick count: mult << (2*res).
module wdog_tmo_calc #(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2,
    parameter int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1)
) (
    input  logic [MULT_W-1:0] mult_i,
    input  logic [RES_W-1:0]  res_i,
    output logic [CNT_W-1:0]  ticks_o
);
    localparam int NRES = 1 << RES_W;

    logic [CNT_W-1:0] cand [NRES];

    for (genvar g = 0; g < NRES; g++) begin : g_scale
        assign cand[g] = CNT_W'(mult_i) << (2 * g);
    end

    assign ticks_o = cand[res_i];
endmodule

// File: rtl/wdog_downcnt.sv
// Tick-driven down counter; a load restarts it, a zero load leaves it idle.
module wdog_downcnt #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic             expire_o
);
    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] rem;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    last_tick;

    assign last_tick = st_q.active && tick_i && (st_q.rem == CNT_W'(1));
    assign expire_o  = last_tick && !load_i;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.active = (load_val_i != '0);
            st_d.rem    = load_val_i;
        end else if (st_q.active && tick_i) begin
            if (last_tick) begin
                st_d.active = 1'b0;
                st_d.rem    = '0;
            end else begin
                st_d.rem = st_q.rem - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wdog_steer.sv
// Watchdog with a single control register and steerable expiry action.
module wdog_steer #(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           tick_i,
    input  logic                           reg_wr_i,
    input  logic                           reg_rd_i,
    input  logic [1+MULT_W+RES_W-1:0]      reg_wdata_i,
    output logic [1+MULT_W+RES_W-1:0]      reg_rdata_o,
    output logic                           wd_flag_o,
    output logic                           irq_pulse_o,
    output logic                           sys_rst_req_o,
    output logic                           mode_clr_o
);
    import wdog_pkg::*;

    localparam int REG_W   = 1 + MULT_W + RES_W;
    localparam int CNT_W   = MULT_W + 2 * ((1 << RES_W) - 1);
    localparam int STEER_B = REG_W - 1;

    typedef struct packed {
        logic [REG_W-1:0] ctl;
        logic             flag;
        logic             irq;
        logic             rreq;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic [REG_W-1:0] sel_val;
    logic [CNT_W-1:0] load_ticks;
    logic             restart;
    logic             expire;
    steer_e           action;

    // a write uses the incoming byte, a read reuses the stored one
    assign sel_val = reg_wr_i ? reg_wdata_i : st_q.ctl;
    assign restart = reg_wr_i || reg_rd_i;
    assign action  = steer_e'(st_q.ctl[STEER_B]);

    wdog_tmo_calc #(
        .MULT_W (MULT_W),
        .RES_W  (RES_W),
        .CNT_W  (CNT_W)
    ) u_calc (
        .mult_i  (sel_val[REG_W-2:RES_W]),
        .res_i   (sel_val[RES_W-1:0]),
        .ticks_o (load_ticks)
    );

    wdog_downcnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load_i     (restart),
        .load_val_i (load_ticks),
        .tick_i     (tick_i),
        .expire_o   (expire)
    );

    always_comb begin
        st_d      = st_q;
        st_d.irq  = 1'b0;
        st_d.rreq = 1'b0;
        if (reg_wr_i) begin
            st_d.ctl  = reg_wdata_i;
            st_d.flag = 1'b0;
        end else if (expire) begin
            st_d.flag = 1'b1;
            if (action == ACT_RST) begin
                st_d.ctl  = '0;
                st_d.rreq = 1'b1;
            end else begin
                st_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata_o   = st_q.ctl;
    assign wd_flag_o     = st_q.flag;
    assign irq_pulse_o   = st_q.irq;
    assign sys_rst_req_o = st_q.rreq;
    assign mode_clr_o    = st_q.rreq;
endmodule

// File: rtl/wdog_steer_chk.sv
module wdog_steer_chk #(
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             flag,
    input logic             irq,
    input logic             rreq,
    input logic             mclr
);
    p_wr_stores_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data == $past(wr_data)));

    p_wr_clears_flag_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !flag);

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (flag && !wr_en) |=> flag);

    p_irq_single_r7: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    p_irq_sets_flag_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag);

    p_rst_clears_reg_r8: assert property (@(posedge clk) disable iff (rst)
        rreq |-> (flag && (rd_data == '0) && !irq && mclr));

    p_rst_single_r8: assert property (@(posedge clk) disable iff (rst)
        rreq |=> !rreq);
endmodule

bind wdog_steer wdog_steer_chk #(.REG_W(REG_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr_i),
    .wr_data (reg_wdata_i),
    .rd_data (reg_rdata_o),
    .flag    (wd_flag_o),
    .irq     (irq_pulse_o),
    .rreq    (sys_rst_req_o),
    .mclr    (mode_clr_o)
);

// File: tb/sim_wdog_steer.sv
module sim_wdog_steer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tk = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [7:0] wd = 8'h00;
    logic [7:0] rdata;
    logic       flag, irq, rreq, mclr;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdog_steer u0 (
        .clk           (clk),
        .rst           (rst),
        .tick_i        (tk),
        .reg_wr_i      (wr),
        .reg_rd_i      (rd),
        .reg_wdata_i   (wd),
        .reg_rdata_o   (rdata),
        .wd_flag_o     (flag),
        .irq_pulse_o   (irq),
        .sys_rst_req_o (rreq),
        .mode_clr_o    (mclr)
    );

    typedef struct packed {
        logic       w;
        logic       r;
        logic       t;
        logic [7:0] d;
        logic       ef;
        logic       ei;
        logic       er;
        logic [7:0] erd;
    } vec_t;

    // one row = one clock; expected outputs are those after that clock edge
    localparam vec_t TBL [21] = '{
        '{1'b1,1'b0,1'b0,8'h05, 1'b0,1'b0,1'b0,8'h05}, // R4 write M=1 R=1 -> 4 ticks
        '{1'b0,1'b0,1'b1,8'h00, 1'b0,1'b0,1'b0,8'h05}, // R2 tick 1
        '{1'b0,1'b0,1'b1,8'h00, 1'b0,1'b0,1'b0,8'h05}, // tick 2
        '{1'b0,1'b0,1'b1,8'h00, 1'b0,1'b0,1'b0,8'h05}, // tick 3
        '{1'b0,1'b0,1'b1,8'h00, 1'b1,1'b1,1'b0,8'h05}, // R7 tick 4 expiry irq
        '{1'b0,1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0,8'h05}, // R6 flag stays
        '{1'b0,1'b0,1'b1,8'h00, 1'b1,1'b0,1'b0,8'h05}, // R7 idle after expiry
        '{1'b0,1'b1,1'b0,8'h00, 1'b1,1'b0,1'b0,8'h05}, // R5 read restarts, flag kept
        '{1'b0,1'b0,1'b1,8'h00, 1'b1,1'b0,1'b0,8'h05},
        '{1'b0,1'b0,1'b1,8'h00, 1'b1,1'b0,1'b0,8'h05},
        '{1'b0,1'b0,1'b1,8'h00, 1'b1,1'b0,1'b0,8'h05},
        '{1'b0,1'b0,1'b1,8'h00, 1'b1,1'b1,1'b0,8'h05}, // R5 expiry after read restart
        '{1'b1,1'b0,1'b0,8'h84, 1'b0,1'b0,1'b0,8'h84}, // R4 write steer=1 M=1 R=0
        '{1'b0,1'b0,1'b1,8'h00, 1'b1,1'b0,1'b1,8'h00}, // R8 reset request, reg cleared
        '{1'b0,1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0,8'h00}, // R8 one cycle only
        '{1'b0,1'b0,1'b1,8'h00, 1'b1,1'b0,1'b0,8'h00},
        '{1'b1,1'b0,1'b0,8'h08, 1'b0,1'b0,1'b0,8'h08}, // write M=2 R=0 -> 2 ticks
        '{1'b0,1'b0,1'b1,8'h00, 1'b0,1'b0,1'b0,8'h08},
        '{1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,8'h08}, // R10 no tick, no progress
        '{1'b0,1'b0,1'b1,8'h00, 1'b1,1'b1,1'b0,8'h08}, // R10 second tick expires
        '{1'b0,1'b0,1'b1,8'h00, 1'b1,1'b0,1'b0,8'h08}  // R7 stays idle
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at the falling edge, pass one rising edge, land on the next falling edge
    task automatic cyc(input logic w, input logic r, input logic t, input logic [7:0] d);
        wr = w; rd = r; tk = t; wd = d;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0; rd = 1'b0; tk = 1'b0; wd = 8'h00;
    endtask

    function automatic logic [11:0] outs();
        return {flag, irq, rreq, mclr, rdata};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int irq_seen;
        @(negedge clk);
        rst = 1'b1;
        cyc(1'b1, 1'b0, 1'b1, 8'hFF);
        cyc(1'b0, 1'b0, 1'b1, 8'h00);
        rst = 1'b0;
        check("R1 reset state", 32'(outs()), 32'h000);
        cyc(1'b0, 1'b0, 1'b1, 8'h00);
        check("R1 idle after reset", 32'(outs()), 32'h000);

        // table walk: R2 R4 R5 R6 R7 R8 R10
        for (int i = 0; i < 21; i++) begin
            cyc(TBL[i].w, TBL[i].r, TBL[i].t, TBL[i].d);
            check($sformatf("R2 table row %0d", i), 32'(outs()),
                  32'({TBL[i].ef, TBL[i].ei, TBL[i].er, TBL[i].er, TBL[i].erd}));
        end

        // R2 largest timeout: M=31 R=3 -> 1984 ticks
        cyc(1'b1, 1'b0, 1'b0, 8'h7F);
        for (int i = 0; i < 1983; i++) cyc(1'b0, 1'b0, 1'b1, 8'h00);
        check("R2 no expiry at 1983 ticks", 32'({flag, irq}), 32'h0);
        cyc(1'b0, 1'b0, 1'b1, 8'h00);
        check("R2 expiry at 1984 ticks", 32'({flag, irq, rdata}), 32'h37F);

        // R3 zero multiplier with nonzero resolution, then 0x00
        cyc(1'b1, 1'b0, 1'b0, 8'h03);
        check("R4 write clears flag", 32'(flag), 32'h0);
        irq_seen = 0;
        for (int i = 0; i < 300; i++) begin
            cyc(1'b0, 1'b0, 1'b1, 8'h00);
            if (irq || flag) irq_seen++;
        end
        check("R3 M=0 disabled", 32'(irq_seen), 32'h0);
        cyc(1'b1, 1'b0, 1'b0, 8'h00);
        for (int i = 0; i < 300; i++) begin
            cyc(1'b0, 1'b0, 1'b1, 8'h00);
            if (irq || flag) irq_seen++;
        end
        check("R3 0x00 disabled", 32'(irq_seen), 32'h0);

        // R9 write collides with final tick
        cyc(1'b1, 1'b0, 1'b0, 8'h04);
        cyc(1'b1, 1'b0, 1'b1, 8'h08);
        check("R9 write beats final tick", 32'(outs()), 32'h008);
        cyc(1'b0, 1'b0, 1'b1, 8'h00);
        check("R9 restarted count pending", 32'({flag, irq}), 32'h0);
        cyc(1'b0, 1'b0, 1'b1, 8'h00);
        check("R9 restarted count expires", 32'({flag, irq}), 32'h3);

        // R9 read collides with final tick
        cyc(1'b1, 1'b0, 1'b0, 8'h08);
        cyc(1'b0, 1'b0, 1'b1, 8'h00);
        cyc(1'b0, 1'b1, 1'b1, 8'h00);
        check("R9 read beats final tick", 32'({flag, irq}), 32'h0);
        cyc(1'b0, 1'b0, 1'b1, 8'h00);
        check("R9 read restart pending", 32'({flag, irq}), 32'h0);
        cyc(1'b0, 1'b0, 1'b1, 8'h00);
        check("R9 read restart expires", 32'({flag, irq}), 32'h3);

        // R9 write and read together act as write
        cyc(1'b1, 1'b1, 1'b0, 8'h0C);
        check("R9 write wins over read", 32'({flag, rdata}), 32'h00C);

        // R1 reset in mid-count
        cyc(1'b1, 1'b0, 1'b0, 8'h04);
        rst = 1'b1;
        cyc(1'b0, 1'b0, 1'b1, 8'h00);
        rst = 1'b0;
        check("R1 mid-count reset", 32'(outs()), 32'h000);
        cyc(1'b0, 1'b0, 1'b1, 8'h00);
        check("R1 no expiry after reset", 32'(outs()), 32'h000);

        ended = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule